// File: doc/BRIEF.md
# Page-Walk Memory Request Scheduler

This block sits between a page-table walker and a memory port that may refuse a request outright or answer it with a negative acknowledgement. It holds at most one pending table read and a stack of pending accessed-bit writebacks. Every cycle it may offer one request on a valid/accept handshake. The order of preference is a just-NACKed request, then the pending read, then the most recently queued writeback.

When the port refuses a request, the scheduler stops sending until the port raises a retry pulse. It counts accepted requests that have not yet been answered. A NACKed response is offered again on the next cycle. If that offer is refused, the request goes back to the read slot or to the writeback stack, according to its type.

A good read response is passed straight to the walker. Sending then pauses until the walker returns a step, which may carry a follow-on read, a writeback, or both. The pause is lifted early only when the writeback stack has no room left. A walk begins with a start request and ends with a one-cycle completion pulse, raised once nothing is pending, nothing is in flight and no step is awaited.

Top module: `wk_req_sched`

## Requirements
- R1: After reset, req_valid, step_ready, walk_done and wk_rsp_valid are 0 and start_ready is 1.
- R2: When a read is pending and writebacks are queued, the read is offered first.
- R3: Queued writebacks are offered one per cycle, newest first (last in, first out).
- R4: A refused offer (req_valid=1, req_accept=0) stops all offers (req_valid=0) until retry_in is seen high.
- R5: After a retry_in pulse, offers resume on the next cycle, starting with the request that had been refused.
- R6: A response with rsp_nack=1 is offered again on the next cycle, with the same address, type (rsp_write) and data. If that offer is refused, the request is held as the pending read (rsp_write=0) or pushed onto the writeback stack (rsp_write=1), and is offered again after retry_in.
- R7: A good read response (rsp_valid=1, rsp_nack=0, rsp_write=0) raises wk_rsp_valid in the same cycle, with wk_rsp_data equal to rsp_data. step_ready then goes high, and nothing is offered before the step is taken, unless the stack is full.
- R8: walk_done pulses for exactly one cycle, only after every accepted request has been answered, with no read, NACKed request or queued writeback pending and no step awaited. start_ready is 0 from the accepted start until that pulse.
- R9: step_ready is 0 while queued writebacks, plus writebacks in flight, plus a NACKed writeback total DEPTH. In that state, queued writebacks are still offered while the step is awaited.
- R10: Good writeback responses (rsp_write=1) are not forwarded: wk_rsp_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Walker starts a walk with a first read |
| start_addr | input | ADDR_W | Address of the first table read |
| start_ready | output | 1 | No walk is in progress |
| step_valid | input | 1 | Walker returns its step after a read response |
| step_rd_valid | input | 1 | Step carries a follow-on read |
| step_rd_addr | input | ADDR_W | Follow-on read address |
| step_wb_valid | input | 1 | Step carries an accessed-bit writeback |
| step_wb_addr | input | ADDR_W | Writeback address |
| step_wb_data | input | DATA_W | Writeback data |
| step_ready | output | 1 | A step is awaited and the stack has room |
| wk_rsp_valid | output | 1 | Good read response forwarded to the walker |
| wk_rsp_data | output | DATA_W | Forwarded read data |
| walk_done | output | 1 | One-cycle walk completion pulse |
| req_valid | output | 1 | Request offered to memory |
| req_write | output | 1 | Offered request is a writeback |
| req_addr | output | ADDR_W | Offered request address |
| req_data | output | DATA_W | Offered writeback data (0 for reads) |
| req_accept | input | 1 | Memory takes the offered request this cycle |
| retry_in | input | 1 | Memory invites a new attempt after a refusal |
| rsp_valid | input | 1 | Memory response |
| rsp_nack | input | 1 | Response is a negative acknowledgement |
| rsp_write | input | 1 | Response belongs to a writeback |
| rsp_addr | input | ADDR_W | Address of the answered request |
| rsp_data | input | DATA_W | Read data, or the writeback data on a NACK |

## Verification
The bench builds the block with DEPTH=4 and 16-bit addresses and data. With that depth, a walk of four steps fills the writeback stack exactly. This makes the full-stack back-pressure reachable, together with writes draining while a step is awaited and the reservation made for writebacks in flight. Walks of one to four writebacks reach every stack fill level, so the newest-first drain order is checked at each depth.

// File: rtl/wk_req_pkg.sv
package wk_req_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_NACK  = 2'd1,
    SRC_READ  = 2'd2,
    SRC_QUEUE = 2'd3
  } src_e;

  // next value of an up/down counter
  function automatic int fly_next(int cnt, bit inc, bit dec);
    return cnt + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

  // writeback storage still free after counting every claimed slot
  function automatic bit wb_has_room(int queued, int wr_fly, bit nack_wr, int depth);
    return (queued + wr_fly + (nack_wr ? 1 : 0)) < depth;
  endfunction

endpackage

// File: rtl/wk_fly_ctr.sv
module wk_fly_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  import wk_req_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= W'(fly_next(int'(cnt), inc, dec));
  end
endmodule

// File: rtl/wk_wb_stack.sv
module wk_wb_stack #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_a,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_data,
  input  logic              push_b,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_data,
  input  logic              pop,
  output logic              nonempty,
  output logic [ADDR_W-1:0] top_addr,
  output logic [DATA_W-1:0] top_data,
  output logic [CNT_W-1:0]  count
);
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];

  // lower write slot takes push_a when present, upper slot takes push_b
  logic              lo_en, hi_en;
  logic [ADDR_W-1:0] lo_addr;
  logic [DATA_W-1:0] lo_data;
  logic [CNT_W-1:0]  lo_idx, hi_idx;

  assign lo_en   = push_a || push_b;
  assign hi_en   = push_a && push_b;
  assign lo_addr = push_a ? a_addr : b_addr;
  assign lo_data = push_a ? a_data : b_data;
  assign lo_idx  = count;
  assign hi_idx  = count + CNT_W'(1);

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          e_addr[gi] <= '0;
          e_data[gi] <= '0;
        end else if (lo_en && lo_idx == CNT_W'(gi)) begin
          e_addr[gi] <= lo_addr;
          e_data[gi] <= lo_data;
        end else if (hi_en && hi_idx == CNT_W'(gi)) begin
          e_addr[gi] <= b_addr;
          e_data[gi] <= b_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (pop)   count <= count - CNT_W'(1);
    else if (hi_en) count <= count + CNT_W'(2);
    else if (lo_en) count <= count + CNT_W'(1);
  end

  always_comb begin
    top_addr = '0;
    top_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count == CNT_W'(i + 1)) begin
        top_addr = e_addr[i];
        top_data = e_data[i];
      end
    end
  end

  assign nonempty = (count != '0);
endmodule

// File: rtl/wk_send_arb.sv
module wk_send_arb #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic               en,
  input  logic               nack_v,
  input  logic               nack_wr,
  input  logic [ADDR_W-1:0]  nack_addr,
  input  logic [DATA_W-1:0]  nack_data,
  input  logic               rd_v,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               q_v,
  input  logic [ADDR_W-1:0]  q_addr,
  input  logic [DATA_W-1:0]  q_data,
  output logic               valid,
  output logic               wr,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  data,
  output wk_req_pkg::src_e   src
);
  import wk_req_pkg::*;

  always_comb begin
    src  = SRC_NONE;
    wr   = 1'b0;
    addr = '0;
    data = '0;
    if (en) begin
      if (nack_v) begin
        src  = SRC_NACK;
        wr   = nack_wr;
        addr = nack_addr;
        data = nack_data;
      end else if (rd_v) begin
        src  = SRC_READ;
        addr = rd_addr;
      end else if (q_v) begin
        src  = SRC_QUEUE;
        wr   = 1'b1;
        addr = q_addr;
        data = q_data;
      end
    end
  end

  assign valid = (src != SRC_NONE);
endmodule

// File: rtl/wk_req_sched.sv
module wk_req_sched #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int FLY_W = $clog2(DEPTH + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              start_ready,
  input  logic              step_valid,
  input  logic              step_rd_valid,
  input  logic [ADDR_W-1:0] step_rd_addr,
  input  logic              step_wb_valid,
  input  logic [ADDR_W-1:0] step_wb_addr,
  input  logic [DATA_W-1:0] step_wb_data,
  output logic              step_ready,
  output logic              wk_rsp_valid,
  output logic [DATA_W-1:0] wk_rsp_data,
  output logic              walk_done,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              req_accept,
  input  logic              retry_in,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic              rsp_write,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_data
);
  import wk_req_pkg::*;

  // registered state
  logic              busy_q, await_q, retry_q;
  logic              rd_v;
  logic [ADDR_W-1:0] rd_addr;
  logic              nack_v, nack_wr;
  logic [ADDR_W-1:0] nack_addr;
  logic [DATA_W-1:0] nack_data;

  // named internal events
  logic              send_en, req_acc, req_refuse;
  logic              nack_in, rd_ok_in, wr_rsp_in;
  logic              requeue_now, requeue_rd, requeue_wr;
  logic              start_acc, step_acc;
  logic              room, quiet;
  logic              q_v, q_pop, q_push_step;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_data;
  logic [CNT_W-1:0]  q_cnt;
  logic [FLY_W-1:0]  fly_cnt, wfly_cnt;
  src_e              src;

  assign req_acc    = req_valid && req_accept;
  assign req_refuse = req_valid && !req_accept;
  assign nack_in    = rsp_valid && rsp_nack;
  assign rd_ok_in   = rsp_valid && !rsp_nack && !rsp_write;
  assign wr_rsp_in  = rsp_valid && rsp_write;

  assign room = wb_has_room(int'(q_cnt), int'(wfly_cnt), nack_v && nack_wr, DEPTH);

  // a step is awaited: hold sending unless the stack is out of room
  assign send_en = !retry_q && !(await_q && room);

  assign start_ready = !busy_q;
  assign start_acc   = start_valid && !busy_q;
  assign step_ready  = await_q && room;
  assign step_acc    = step_valid && step_ready;

  assign wk_rsp_valid = rd_ok_in;
  assign wk_rsp_data  = rsp_data;

  // the NACK slot lives one cycle: sent, or put back by type
  assign requeue_now = nack_v && !(req_acc && src == SRC_NACK);
  assign requeue_rd  = requeue_now && !nack_wr;
  assign requeue_wr  = requeue_now && nack_wr;

  assign q_pop       = req_acc && src == SRC_QUEUE;
  assign q_push_step = step_acc && step_wb_valid;

  wk_send_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .en        (send_en),
    .nack_v    (nack_v),
    .nack_wr   (nack_wr),
    .nack_addr (nack_addr),
    .nack_data (nack_data),
    .rd_v      (rd_v),
    .rd_addr   (rd_addr),
    .q_v       (q_v),
    .q_addr    (q_addr),
    .q_data    (q_data),
    .valid     (req_valid),
    .wr        (req_write),
    .addr      (req_addr),
    .data      (req_data),
    .src       (src)
  );

  wk_wb_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_a   (requeue_wr),
    .a_addr   (nack_addr),
    .a_data   (nack_data),
    .push_b   (q_push_step),
    .b_addr   (step_wb_addr),
    .b_data   (step_wb_data),
    .pop      (q_pop),
    .nonempty (q_v),
    .top_addr (q_addr),
    .top_data (q_data),
    .count    (q_cnt)
  );

  // one counter for all traffic, one for writebacks alone
  wk_fly_ctr #(.W(FLY_W)) u_fly_all (
    .clk (clk), .rst_n (rst_n),
    .inc (req_acc), .dec (rsp_valid),
    .cnt (fly_cnt)
  );

  wk_fly_ctr #(.W(FLY_W)) u_fly_wr (
    .clk (clk), .rst_n (rst_n),
    .inc (req_acc && req_write), .dec (wr_rsp_in),
    .cnt (wfly_cnt)
  );

  assign quiet = (fly_cnt == '0) && !rd_v && !q_v && !nack_v && !await_q;
  assign walk_done = busy_q && quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      await_q   <= 1'b0;
      retry_q   <= 1'b0;
      rd_v      <= 1'b0;
      rd_addr   <= '0;
      nack_v    <= 1'b0;
      nack_wr   <= 1'b0;
      nack_addr <= '0;
      nack_data <= '0;
    end else begin
      if (start_acc)      busy_q <= 1'b1;
      else if (walk_done) busy_q <= 1'b0;

      if (rd_ok_in)      await_q <= 1'b1;
      else if (step_acc) await_q <= 1'b0;

      if (req_refuse)    retry_q <= 1'b1;
      else if (retry_in) retry_q <= 1'b0;

      nack_v <= nack_in;
      if (nack_in) begin
        nack_wr   <= rsp_write;
        nack_addr <= rsp_addr;
        nack_data <= rsp_data;
      end

      if (start_acc) begin
        rd_v    <= 1'b1;
        rd_addr <= start_addr;
      end else if (step_acc && step_rd_valid) begin
        rd_v    <= 1'b1;
        rd_addr <= step_rd_addr;
      end else if (requeue_rd) begin
        rd_v    <= 1'b1;
        rd_addr <= nack_addr;
      end else if (req_acc && src == SRC_READ) begin
        rd_v    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wk_req_sched_chk.sv
module wk_req_sched_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 3,
  parameter int FLY_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_accept,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_nack,
  input logic              rsp_write,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              send_en,
  input logic              rd_v,
  input logic [CNT_W-1:0]  q_cnt,
  input logic [FLY_W-1:0]  fly_cnt,
  input logic              walk_done
);
  // R2
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> !rd_v);

  // R4
  refuse_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_accept) |=> !req_valid);

  // R6
  nack_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nack) |=> (!send_en ||
      (req_valid && req_addr == $past(rsp_addr) && req_write == $past(rsp_write))));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> (fly_cnt == '0 && !req_valid));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_cnt) <= DEPTH);

  // R8
  fly_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_accept && !rsp_valid) |=> (fly_cnt == $past(fly_cnt) + FLY_W'(1)));
endmodule

bind wk_req_sched wk_req_sched_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FLY_W(FLY_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_accept (req_accept),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_nack   (rsp_nack),
  .rsp_write  (rsp_write),
  .rsp_addr   (rsp_addr),
  .send_en    (send_en),
  .rd_v       (rd_v),
  .q_cnt      (q_cnt),
  .fly_cnt    (fly_cnt),
  .walk_done  (walk_done)
);

// File: tb/tb_wk_req_sched.sv
`timescale 1ns/1ps
module tb_wk_req_sched;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start_valid = 0, step_valid = 0, step_rd_valid = 0, step_wb_valid = 0;
  logic [AW-1:0] start_addr = 0, step_rd_addr = 0, step_wb_addr = 0;
  logic [DW-1:0] step_wb_data = 0;
  logic          retry_in = 0, rsp_valid = 0, rsp_nack = 0, rsp_write = 0;
  logic [AW-1:0] rsp_addr = 0;
  logic [DW-1:0] rsp_data = 0;
  logic          start_ready, step_ready, wk_rsp_valid, walk_done;
  logic [DW-1:0] wk_rsp_data;
  logic          req_valid, req_write, req_accept;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;

  // 0: accept reads only, 1: accept all, 2: refuse all
  int acc_mode = 2;
  assign req_accept = (acc_mode == 1) || (acc_mode == 0 && !req_write);

  wk_req_sched #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_addr(start_addr), .start_ready(start_ready),
    .step_valid(step_valid), .step_rd_valid(step_rd_valid), .step_rd_addr(step_rd_addr),
    .step_wb_valid(step_wb_valid), .step_wb_addr(step_wb_addr), .step_wb_data(step_wb_data),
    .step_ready(step_ready), .wk_rsp_valid(wk_rsp_valid), .wk_rsp_data(wk_rsp_data),
    .walk_done(walk_done), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .req_accept(req_accept),
    .retry_in(retry_in), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
    .rsp_write(rsp_write), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  // log of accepted requests and count of completion pulses
  logic          lg_clr = 0;
  int            lg_n = 0, done_n = 0;
  logic          lg_wr [32];
  logic [AW-1:0] lg_addr [32];
  logic [DW-1:0] lg_data [32];
  always @(posedge clk) begin
    if (lg_clr) begin
      lg_n   <= 0;
      done_n <= 0;
    end else if (rst_n) begin
      if (req_valid && req_accept && lg_n < 32) begin
        lg_wr[lg_n]   <= req_write;
        lg_addr[lg_n] <= req_addr;
        lg_data[lg_n] <= req_data;
        lg_n          <= lg_n + 1;
      end
      if (walk_done) done_n <= done_n + 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    lg_clr = 1; cyc(1); lg_clr = 0;
  endtask

  task automatic start_walk(logic [AW-1:0] a);
    start_valid = 1; start_addr = a;
    cyc(1);
    start_valid = 0;
  endtask

  task automatic pulse_retry();
    retry_in = 1; cyc(1); retry_in = 0;
  endtask

  task automatic mem_rsp(bit nack, bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    rsp_valid = 1; rsp_nack = nack; rsp_write = wr; rsp_addr = a; rsp_data = d;
    #1;
    if (!nack && !wr) begin
      chk("R7 wk_rsp_valid", wk_rsp_valid, 1);
      chk("R7 wk_rsp_data", wk_rsp_data, d);
    end
    if (!nack && wr) chk("R10 write rsp not forwarded", wk_rsp_valid, 0);
    cyc(1);
    rsp_valid = 0; rsp_nack = 0; rsp_write = 0;
  endtask

  task automatic step(bit rv, logic [AW-1:0] ra, bit wv, logic [AW-1:0] wa, logic [DW-1:0] wd);
    while (!step_ready) cyc(1);
    step_valid = 1; step_rd_valid = rv; step_rd_addr = ra;
    step_wb_valid = wv; step_wb_addr = wa; step_wb_data = wd;
    cyc(1);
    step_valid = 0; step_rd_valid = 0; step_wb_valid = 0;
  endtask

  function automatic logic [AW-1:0] rda(logic [AW-1:0] b, int k);
    return b + AW'(k * 16);
  endfunction
  function automatic logic [AW-1:0] wba(logic [AW-1:0] b, int k);
    return b + AW'(256 + k);
  endfunction
  function automatic logic [DW-1:0] wbd(logic [AW-1:0] b, int k);
    return DW'(b) ^ DW'(16'h5A00 + k);
  endfunction

  // vectors: {writebacks in the walk, base address}
  localparam logic [3:0]    VN [4] = '{4'd1, 4'd2, 4'd3, 4'd4};
  localparam logic [AW-1:0] VB [4] = '{16'h1000, 16'h2000, 16'h3000, 16'h4000};

  // walk of n steps; reads accepted, writes refused until the drain
  task automatic run_vector(int n, logic [AW-1:0] b);
    clear_log();
    acc_mode = 0;
    start_walk(b);
    chk("R8 start_ready low in walk", start_ready, 0);
    cyc(2);
    for (int k = 0; k < n; k++) begin
      mem_rsp(0, 0, rda(b, k), DW'(k * 3 + 1));
      step(k < n - 1, rda(b, k + 1), 1, wba(b, k), wbd(b, k));
      pulse_retry();
      cyc(3);
    end
    acc_mode = 1;
    pulse_retry();
    cyc(n + 2);
    chk("R3 log length", lg_n, 2 * n);
    for (int j = 0; j < n; j++) begin
      chk("R2 read order", {lg_wr[j], lg_addr[j]}, {1'b0, rda(b, j)});
    end
    for (int j = 0; j < n; j++) begin
      chk("R3 lifo addr", {lg_wr[n + j], lg_addr[n + j]}, {1'b1, wba(b, n - 1 - j)});
      chk("R3 lifo data", lg_data[n + j], wbd(b, n - 1 - j));
    end
    chk("R8 no done with writes in flight", done_n, 0);
    for (int j = 0; j < n; j++) mem_rsp(0, 1, wba(b, j), 0);
    cyc(2);
    chk("R8 one done pulse", done_n, 1);
    chk("R8 start_ready after done", start_ready, 1);
  endtask

  task automatic run_all();
    cyc(2);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 start_ready", start_ready, 1);
    chk("R1 step_ready", step_ready, 0);
    chk("R1 walk_done", walk_done, 0);
    chk("R1 wk_rsp_valid", wk_rsp_valid, 0);
    rst_n = 1;
    cyc(2);

    for (int v = 0; v < 4; v++) run_vector(int'(VN[v]), VB[v]);

    // refusal and retry, NACK of a read and of a write
    clear_log();
    acc_mode = 2;
    start_walk(16'h7000);
    cyc(1);
    for (int i = 0; i < 4; i++) begin
      chk("R4 held after refusal", req_valid, 0);
      cyc(1);
    end
    pulse_retry();
    chk("R5 offer resumes", {req_valid, req_write, req_addr}, {2'b10, 16'h7000});
    acc_mode = 1;
    cyc(1);
    acc_mode = 2;
    mem_rsp(1, 0, 16'h7000, 0);
    chk("R6 nacked read reissued", {req_valid, req_write, req_addr}, {2'b10, 16'h7000});
    cyc(1);
    chk("R6 refused reissue holds", req_valid, 0);
    acc_mode = 1;
    pulse_retry();
    chk("R6 read requeued to slot", {req_valid, req_write, req_addr}, {2'b10, 16'h7000});
    cyc(1);
    mem_rsp(0, 0, 16'h7000, 16'h1234);
    chk("R7 nothing offered before step", req_valid, 0);
    step(0, 0, 1, 16'h7100, 16'hBEEF);
    cyc(1);
    acc_mode = 2;
    mem_rsp(1, 1, 16'h7100, 16'hBEEF);
    chk("R6 nacked write reissued", {req_valid, req_write, req_addr, req_data},
        {2'b11, 16'h7100, 16'hBEEF});
    cyc(1);
    acc_mode = 1;
    pulse_retry();
    chk("R6 write requeued to stack", {req_valid, req_write, req_addr, req_data},
        {2'b11, 16'h7100, 16'hBEEF});
    cyc(1);
    mem_rsp(0, 1, 16'h7100, 0);
    cyc(2);
    chk("R8 done after nack walk", done_n, 1);

    // full stack back-pressure and draining while a step is awaited
    clear_log();
    acc_mode = 0;
    start_walk(16'h8000);
    cyc(2);
    for (int k = 0; k < 4; k++) begin
      mem_rsp(0, 0, rda(16'h8000, k), 0);
      step(1, rda(16'h8000, k + 1), 1, wba(16'h8000, k), wbd(16'h8000, k));
      pulse_retry();
      cyc(3);
    end
    mem_rsp(0, 0, rda(16'h8000, 4), 0);
    chk("R9 step_ready low when full", step_ready, 0);
    acc_mode = 1;
    pulse_retry();
    cyc(5);
    chk("R9 writes drain while awaiting", lg_n, 9);
    chk("R3 drain newest first", lg_addr[5], wba(16'h8000, 3));
    chk("R9 in-flight writes keep it full", step_ready, 0);
    mem_rsp(0, 1, wba(16'h8000, 3), 0);
    chk("R9 room after a write retires", step_ready, 1);
    step(0, 0, 0, 0, 0);
    for (int j = 0; j < 3; j++) mem_rsp(0, 1, wba(16'h8000, j), 0);
    cyc(2);
    chk("R8 done after full walk", done_n, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule